// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block watches one asynchronous external pin and raises a sticky interrupt request when a chosen edge appears on it. A two-stage synchronizer brings the pin into the clock domain. An optional digital noise filter follows it and samples either every cycle, every 8th cycle or every 32nd cycle. The filtered level goes to an edge detector that can respond to a falling edge, a rising edge or both edges.

Software configures the block through a small register port with two registers. The control register holds the enable, edge-mode and polarity bits. The filter register holds the sampling-rate select. The request flag stays high until a clear pulse arrives. A rewrite that flips the edge-mode bit while the source is enabled raises the flag on purpose, so software clears the flag after any such change. The sampling strobes come from a free-running prescaler as single-cycle enables, and no derived clock is produced.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset, irq_req is 0 and both registers read as 0.
- R2: cfg_sel=0 selects the control register (bit0 enable, bit1 both-edge mode, bit2 rising polarity). cfg_sel=1 selects the filter register (bits 1:0 sampling select). Bits that are not defined read as 0. cfg_rdata shows the register selected in the previous cycle, and a register holds its value unless it is written.
- R3: The filter select codes are 00 bypass, 01 sample every cycle, 10 sample every 8th cycle, 11 sample every 32nd cycle. While filtering, the level changes only after three consecutive samples agree, so a pulse spanning at most two samples is rejected and one spanning three or more samples passes.
- R4: In bypass, a pin change reaches the edge detector straight from the synchronizer. A pin change that is set up before clock edge 1 sets irq_req at clock edge 3, and a one-cycle pulse is detected.
- R5: While the enable bit is 0, no pin edge sets irq_req.
- R6: When both-edge mode is 0, polarity 0 selects falling edges and polarity 1 selects rising edges. When both-edge mode is 1, either edge sets irq_req and the polarity bit is ignored.
- R7: irq_req stays set until irq_clr is high at a clock edge, and it is 0 after that edge.
- R8: If a set condition and irq_clr occur at the same clock edge, irq_req ends up 1.
- R9: A control write that changes the both-edge bit while the enable bit is currently 1 sets irq_req at that write edge. A write that leaves the bit unchanged does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 1 | Asynchronous external interrupt pin |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 filter |
| cfg_wdata | input | 3 | Write data |
| cfg_rdata | output | 8 | Registered read data of the register selected last cycle |
| irq_clr | input | 1 | Clear pulse for the request flag |
| irq_req | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is a clear that lands on the same clock edge as a new qualifying edge. The stimulus reaches it in bypass mode, where the latency from the pin to the flag is exactly three edges. The bench raises the pin on a falling clock edge and holds irq_clr high only in the cycle before the third rising edge. The filter windows are the second hard area. For each rate, the bench drives pulses whose widths it computes from the sampling period. The widths cover two periods, which must be rejected, and three periods plus margin, which must pass, wherever the prescaler phase happens to fall.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    FLT_OFF = 2'b00,
    FLT_F1  = 2'b01,
    FLT_F8  = 2'b10,
    FLT_F32 = 2'b11
  } flt_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_BOTH_BIT = 1;
  localparam int CTRL_RISE_BIT = 2;
  localparam int CTRL_W        = 3;
endpackage

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
  parameter int MID_LOG  = 3,
  parameter int SLOW_LOG = 5
) (
  input  logic clk,
  input  logic rst,
  output logic stb_mid,
  output logic stb_slow
);
  logic [SLOW_LOG-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign stb_mid  = &cnt_q[MID_LOG-1:0];
  assign stb_slow = &cnt_q;

  // R3: every slow strobe coincides with a mid strobe
  p_slow_in_mid_r3: assert property (@(posedge clk) disable iff (rst)
    stb_slow |-> stb_mid);
endmodule

// File: rtl/irq_noise_filter.sv
module irq_noise_filter
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_async,
  input  flt_sel_e fsel,
  input  logic     stb_mid,
  input  logic     stb_slow,
  output logic     level_o
);
  localparam int HW = FILT_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hist_q;
  logic                   lvl_q;
  logic                   s_in;
  logic                   stb;
  logic                   agree;

  assign s_in = sync_q[SYNC_STAGES-1];

  always_comb begin
    case (fsel)
      FLT_F1:  stb = 1'b1;
      FLT_F8:  stb = stb_mid;
      FLT_F32: stb = stb_slow;
      default: stb = 1'b0;
    endcase
  end

  assign agree = s_in ? (&hist_q) : ~(|hist_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
      if (fsel == FLT_OFF) begin
        hist_q <= {HW{s_in}};
        lvl_q  <= s_in;
      end else if (stb) begin
        hist_q <= {hist_q[HW-2:0], s_in};
        if (agree) lvl_q <= s_in;
      end
    end
  end

  assign level_o = (fsel == FLT_OFF) ? s_in : lvl_q;

  // R3: filtered level moves only on a sampling strobe
  p_lvl_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (fsel != FLT_OFF && !stb) |=> $stable(lvl_q));
endmodule

// File: rtl/irq_edge_flag.sv
module irq_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic en,
  input  logic both,
  input  logic rise_pol,
  input  logic mode_flip,
  input  logic clr,
  output logic irq_o
);
  logic prev_q;
  logic rise_ev;
  logic fall_ev;
  logic qual;
  logic hit;

  assign rise_ev = level_i & ~prev_q;
  assign fall_ev = ~level_i & prev_q;

  always_comb begin
    if (both)          qual = rise_ev | fall_ev;
    else if (rise_pol) qual = rise_ev;
    else               qual = fall_ev;
  end

  assign hit = (en & qual) | mode_flip;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (hit)      irq_o <= 1'b1;
      else if (clr) irq_o <= 1'b0;
    end
  end

  // R7: flag is sticky without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr) |=> irq_o);
  // R5: no new request while disabled
  p_no_set_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !en) |=> !irq_o);
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 3,
  parameter int MID_LOG      = 3,
  parameter int SLOW_LOG     = 5,
  parameter int DW           = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_async,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              irq_clr,
  output logic              irq_req
);
  logic     en_q, both_q, rise_q;
  flt_sel_e fsel_q;
  logic     stb_mid, stb_slow;
  logic     level;
  logic     ctrl_wr;
  logic     mode_flip;

  assign ctrl_wr   = cfg_wr & ~cfg_sel;
  assign mode_flip = ctrl_wr & en_q & (cfg_wdata[CTRL_BOTH_BIT] != both_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      both_q    <= 1'b0;
      rise_q    <= 1'b0;
      fsel_q    <= FLT_OFF;
      cfg_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= cfg_wdata[CTRL_EN_BIT];
        both_q <= cfg_wdata[CTRL_BOTH_BIT];
        rise_q <= cfg_wdata[CTRL_RISE_BIT];
      end
      if (cfg_wr && cfg_sel) fsel_q <= flt_sel_e'(cfg_wdata[1:0]);
      if (cfg_sel) cfg_rdata <= {{(DW-2){1'b0}}, fsel_q};
      else         cfg_rdata <= {{(DW-3){1'b0}}, rise_q, both_q, en_q};
    end
  end

  irq_prescaler #(.MID_LOG(MID_LOG), .SLOW_LOG(SLOW_LOG)) u_pre (
    .clk(clk), .rst(rst), .stb_mid(stb_mid), .stb_slow(stb_slow)
  );

  irq_noise_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_SAMPLES(FILT_SAMPLES)) u_filt (
    .clk(clk), .rst(rst), .pin_async(pin_async), .fsel(fsel_q),
    .stb_mid(stb_mid), .stb_slow(stb_slow), .level_o(level)
  );

  irq_edge_flag u_flag (
    .clk(clk), .rst(rst), .level_i(level), .en(en_q), .both(both_q),
    .rise_pol(rise_q), .mode_flip(mode_flip), .clr(irq_clr), .irq_o(irq_req)
  );

  // R2: configuration holds without a write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(en_q) && $stable(both_q) && $stable(rise_q) && $stable(fsel_q)));
endmodule

// File: tb/pin_irq_detect_tb_top.sv
module pin_irq_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_async = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq_clr = 1'b0;
  logic       irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_detect dut_i (
    .clk(clk), .rst(rst), .pin_async(pin_async), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_clr(irq_clr), .irq_req(irq_req)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [2:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, output int v);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    v = int'(cfg_rdata);
  endtask

  task automatic clear();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    pin_async = 1'b1;
    cyc(w);
    pin_async = 1'b0;
  endtask

  function automatic int period(input int f);
    if (f == 2) return 8;
    if (f == 3) return 32;
    return 1;
  endfunction

  initial begin
    int v;
    cyc(5);
    rst = 1'b0;
    @(negedge clk);
    chk(int'(irq_req), 0, "R1 irq after reset");
    rd(0, v); chk(v, 0, "R1 ctrl after reset");
    rd(1, v); chk(v, 0, "R1 filter after reset");

    // R2 register map and padding
    wr(0, 3'b111); rd(0, v); chk(v, 7, "R2 ctrl readback");
    wr(1, 3'b111); rd(1, v); chk(v, 3, "R2 filter readback pads upper bits");
    rd(0, v); chk(v, 7, "R2 ctrl holds");
    wr(1, 3'b000); wr(0, 3'b000); cyc(3); clear(); cyc(2);
    chk(int'(irq_req), 0, "R7 clear drops flag");

    // R4 bypass latency: rising, enabled
    wr(0, 3'b101); cyc(3); clear();
    @(negedge clk); pin_async = 1'b1;
    cyc(2); chk(int'(irq_req), 0, "R4 not yet after two edges");
    cyc(1); chk(int'(irq_req), 1, "R4 set at third edge");
    cyc(4); chk(int'(irq_req), 1, "R7 sticky");
    pin_async = 1'b0; cyc(6); clear(); @(negedge clk);
    chk(int'(irq_req), 0, "R7 cleared");
    pulse(1); cyc(6); chk(int'(irq_req), 1, "R4 one-cycle pulse in bypass");
    clear(); cyc(2);

    // R8 set beats clear on the same edge
    @(negedge clk); pin_async = 1'b1;
    cyc(2); irq_clr = 1'b1;
    cyc(1); irq_clr = 1'b0;
    chk(int'(irq_req), 1, "R8 set wins over clear");
    pin_async = 1'b0; cyc(5); clear(); @(negedge clk);
    chk(int'(irq_req), 0, "R8 later clear works");

    // R9 mode-bit rewrite while enabled
    wr(0, 3'b111); chk(int'(irq_req), 1, "R9 mode flip sets flag");
    clear(); wr(0, 3'b111); cyc(2);
    chk(int'(irq_req), 0, "R9 unchanged mode no set");

    // R5 disabled source
    wr(0, 3'b110); cyc(2); clear(); cyc(2);
    pulse(20); cyc(20);
    chk(int'(irq_req), 0, "R5 disabled ignores edges");

    // R6 / R3 sweep: filter mode x edge config
    for (int f = 0; f < 4; f++) begin
      for (int e = 0; e < 3; e++) begin
        logic [2:0] c;
        int er, ef;
        c = (e == 0) ? 3'b000 : (e == 1) ? 3'b100 : 3'b010;
        er = (e != 0) ? 1 : 0;
        ef = (e != 1) ? 1 : 0;
        wr(0, c); wr(1, 3'(f)); wr(0, c | 3'b001);
        cyc(10); clear(); cyc(2);
        @(negedge clk); pin_async = 1'b1; cyc(160);
        chk(int'(irq_req), er, $sformatf("R6 rise f=%0d e=%0d", f, e));
        clear();
        @(negedge clk); pin_async = 1'b0; cyc(160);
        chk(int'(irq_req), ef, $sformatf("R6 fall f=%0d e=%0d", f, e));
        clear();
      end
    end

    // R3 filter windows, rising polarity
    for (int f = 0; f < 4; f++) begin
      int p;
      p = period(f);
      wr(0, 3'b100); wr(1, 3'(f)); wr(0, 3'b101);
      cyc(10); clear(); cyc(2);
      if (f != 0) begin
        pulse(2 * p); cyc(160);
        chk(int'(irq_req), 0, $sformatf("R3 reject width %0d f=%0d", 2 * p, f));
        clear();
      end
      pulse(3 * p + 2); cyc(160);
      chk(int'(irq_req), 1, $sformatf("R3 pass width %0d f=%0d", 3 * p + 2, f));
      clear(); cyc(2);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule